// File: doc/BRIEF.md
# Cascaded Biquad Filter Chain

This block filters 16-bit signed samples for several channels at once, all sampled on the same instant. Each channel runs its sample through a fixed cascade of seven second-order sections. Together they form a filter of order up to fourteen. Every section has its own five coefficients in signed Q2.14 and a small mode word. The mode word picks the numerator shape (general, lowpass, highpass or bandpass), an optional absolute-value step on the section output, and a bypass that turns the section into a wire. Bypassed sections allow lower filter orders.

One sample vector is accepted when `in_valid` is high and `in_ready` is high. The block then evaluates one section per clock for every channel in parallel. It presents the filtered vector with a one-cycle `out_valid` pulse seven cycles after acceptance, so a new vector can be taken every eight cycles. At a 125 MHz clock this leaves ample room for an 800 ksps sample rate.

Coefficients and mode words are loaded through a simple write port into a shadow copy. The shadow copy becomes active only at the moment a sample is accepted, so no sample ever sees a half-updated section.

Top module: `biquad_cascade`

## Requirements
- R1: A sample vector accepted at clock edge k has its result on `out_data` with `out_valid` high for exactly one cycle, directly after edge k+7. `in_ready` is low from edge k+1 until edge k+7, and section s (0..6) feeds section s+1.
- R2: A section that is not bypassed computes acc = N − a1·y[n−1] − a2·y[n−2] in a wide accumulator. Its output is floor(acc / 2^14), clamped to 16 bits. x[n−1] and x[n−2] are that section's earlier inputs, and y[n−1] and y[n−2] are its earlier clamped outputs.
- R3: The type field (mode bits [1:0]) selects N as follows. Code 0 gives b0·x + b1·x[n−1] + b2·x[n−2]. Code 1 (lowpass) gives b0·(x + 2x[n−1] + x[n−2]). Code 2 (highpass) gives b0·(x − 2x[n−1] + x[n−2]). Code 3 (bandpass) gives b0·(x − x[n−2]).
- R4: A section result outside the range −32768..32767 saturates to the nearer limit instead of wrapping.
- R5: When mode bit 2 (rectify) is set, the section passes on |y|, with −32768 mapped to 32767. Its feedback history still records the unrectified y.
- R6: When mode bit 3 (bypass) is set, the section output equals its input and the section's history stays unchanged.
- R7: A write with `cfg_we` high loads `cfg_wdata` into channel `cfg_ch`, section `cfg_sec`. The field is chosen by `cfg_field`: 0 = b0, 1 = b1, 2 = b2, 3 = a1, 4 = a2, 5 = mode word (data bits [3:0]). Field codes 6 and 7 and section index 7 change nothing.
- R8: Writes go to a shadow copy that is copied to the active set on the edge that accepts a sample. A write on that same edge affects only the following sample. Writes made while a sample is in flight do not alter it.
- R9: Reset clears all section histories to zero and sets every section to bypass with zero coefficients. After reset, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1.
- R10: Each channel has its own coefficients and history. A write to one channel does not change the result of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coefficient/mode write strobe |
| cfg_ch | input | 2 | Channel index of the write |
| cfg_sec | input | 3 | Section index of the write (0..6) |
| cfg_field | input | 3 | Field code of the write |
| cfg_wdata | input | 16 | Write data |
| in_valid | input | 1 | Input sample vector is valid |
| in_ready | output | 1 | Block can accept a sample vector |
| in_data | input | 64 | Input samples, channel c in bits [16c+15:16c] |
| out_valid | output | 1 | One-cycle pulse: result vector valid |
| out_data | output | 64 | Filtered samples, channel c in bits [16c+15:16c] |

## Verification
A coefficient write and the acceptance of a sample can land on the same clock edge. The bench provokes this by raising `cfg_we` and `in_valid` in the same cycle with a changed b0. The result of that sample must match a model that used the old coefficient, and the next sample must match the new one. A second case issues a write while a sample is still moving through the sections, and expects no effect until the next acceptance.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  parameter int SW    = 16;          // sample width
  parameter int CW    = 16;          // coefficient width
  parameter int FRAC  = 14;          // fraction bits of coefficients
  parameter int ACC_W = 40;          // accumulator width
  parameter int FLD_W = 3;           // write field code width

  localparam logic [FLD_W-1:0] F_B0   = 3'd0;
  localparam logic [FLD_W-1:0] F_B1   = 3'd1;
  localparam logic [FLD_W-1:0] F_B2   = 3'd2;
  localparam logic [FLD_W-1:0] F_A1   = 3'd3;
  localparam logic [FLD_W-1:0] F_A2   = 3'd4;
  localparam logic [FLD_W-1:0] F_MODE = 3'd5;

  typedef enum logic [1:0] {
    K_GENERAL = 2'd0,
    K_LOWPASS = 2'd1,
    K_HIGHPASS = 2'd2,
    K_BANDPASS = 2'd3
  } kind_e;

  typedef struct packed {
    logic  bypass;
    logic  rect;
    kind_e kind;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  typedef struct packed {
    logic signed [CW-1:0] b0;
    logic signed [CW-1:0] b1;
    logic signed [CW-1:0] b2;
    logic signed [CW-1:0] a1;
    logic signed [CW-1:0] a2;
    mode_t                mode;
  } sec_cfg_t;

  localparam logic signed [ACC_W-1:0] ACC_HI = ACC_W'((64'sd1 <<< (SW - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] ACC_LO = -ACC_HI - ACC_W'(1);

  function automatic sec_cfg_t cfg_reset();
    sec_cfg_t r;
    r = '0;
    r.mode.bypass = 1'b1;
    return r;
  endfunction

  // Feed-forward sum; its shape depends on the section type.
  function automatic logic signed [ACC_W-1:0] numer(
    input kind_e kind,
    input logic signed [CW-1:0] b0, input logic signed [CW-1:0] b1,
    input logic signed [CW-1:0] b2,
    input logic signed [SW-1:0] x0, input logic signed [SW-1:0] x1,
    input logic signed [SW-1:0] x2);
    logic signed [ACC_W-1:0] e0, e1, e2, c0, c1, c2;
    e0 = ACC_W'(x0);
    e1 = ACC_W'(x1);
    e2 = ACC_W'(x2);
    c0 = ACC_W'(b0);
    c1 = ACC_W'(b1);
    c2 = ACC_W'(b2);
    case (kind)
      K_LOWPASS:  return c0 * (e0 + (e1 <<< 1) + e2);
      K_HIGHPASS: return c0 * (e0 - (e1 <<< 1) + e2);
      K_BANDPASS: return c0 * (e0 - e2);
      default:    return c0 * e0 + c1 * e1 + c2 * e2;
    endcase
  endfunction

  function automatic logic signed [ACC_W-1:0] fback(
    input logic signed [CW-1:0] a1, input logic signed [CW-1:0] a2,
    input logic signed [SW-1:0] y1, input logic signed [SW-1:0] y2);
    return ACC_W'(a1) * ACC_W'(y1) + ACC_W'(a2) * ACC_W'(y2);
  endfunction

  // Drop the fraction (floor) and clamp to the sample range.
  function automatic logic signed [SW-1:0] scale_sat(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] sh;
    sh = acc >>> FRAC;
    if (sh > ACC_HI)      return SW'(ACC_HI);
    else if (sh < ACC_LO) return SW'(ACC_LO);
    else                  return SW'(sh);
  endfunction

  function automatic logic signed [SW-1:0] magnitude(input logic signed [SW-1:0] v);
    if (v == {1'b1, {(SW-1){1'b0}}}) return {1'b0, {(SW-1){1'b1}}};
    else if (v < 0)                   return -v;
    else                              return v;
  endfunction
endpackage

// File: rtl/bq_coef_bank.sv
module bq_coef_bank
  import biquad_pkg::*;
#(
  parameter int NUM_SEC = 7,
  parameter int SEC_W   = $clog2(NUM_SEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEC_W-1:0] wr_sec,
  input  logic [FLD_W-1:0] wr_field,
  input  logic [CW-1:0]    wr_data,
  input  logic             commit,
  input  logic [SEC_W-1:0] rd_sec,
  output sec_cfg_t         rd_cfg
);
  localparam logic [SEC_W:0] SEC_LIM = (SEC_W + 1)'(NUM_SEC);

  sec_cfg_t [NUM_SEC-1:0] shadow_q;
  sec_cfg_t [NUM_SEC-1:0] active_q;

  logic sec_ok;
  logic field_ok;
  logic wr_hit;

  assign sec_ok   = {1'b0, wr_sec} < SEC_LIM;
  assign field_ok = wr_field <= F_MODE;
  assign wr_hit   = we && sec_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SEC; i++) shadow_q[i] <= cfg_reset();
    end else if (wr_hit) begin
      case (wr_field)
        F_B0:    shadow_q[wr_sec].b0   <= wr_data;
        F_B1:    shadow_q[wr_sec].b1   <= wr_data;
        F_B2:    shadow_q[wr_sec].b2   <= wr_data;
        F_A1:    shadow_q[wr_sec].a1   <= wr_data;
        F_A2:    shadow_q[wr_sec].a2   <= wr_data;
        F_MODE:  shadow_q[wr_sec].mode <= mode_t'(wr_data[MODE_W-1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SEC; i++) active_q[i] <= cfg_reset();
    end else if (commit) begin
      active_q <= shadow_q;
    end
  end

  assign rd_cfg = active_q[rd_sec];

  // R8: the active set moves only on a sample acceptance
  p_hold_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_q));

  // R7: an out-of-range field or section leaves the shadow set untouched
  p_bad_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (!field_ok || !sec_ok)) |=> $stable(shadow_q));
endmodule

// File: rtl/bq_section_math.sv
module bq_section_math
  import biquad_pkg::*;
(
  input  sec_cfg_t             cfg,
  input  logic signed [SW-1:0] x0,
  input  logic signed [SW-1:0] x1,
  input  logic signed [SW-1:0] x2,
  input  logic signed [SW-1:0] y1,
  input  logic signed [SW-1:0] y2,
  output logic signed [SW-1:0] y_filt,
  output logic signed [SW-1:0] y_out
);
  logic signed [ACC_W-1:0] ff_sum;
  logic signed [ACC_W-1:0] fb_sum;
  logic signed [ACC_W-1:0] acc;

  always_comb begin
    ff_sum = numer(cfg.mode.kind, cfg.b0, cfg.b1, cfg.b2, x0, x1, x2);
    fb_sum = fback(cfg.a1, cfg.a2, y1, y2);
    acc    = ff_sum - fb_sum;
    y_filt = scale_sat(acc);
    if (cfg.mode.bypass)    y_out = x0;
    else if (cfg.mode.rect) y_out = magnitude(y_filt);
    else                    y_out = y_filt;
  end
endmodule

// File: rtl/bq_channel.sv
module bq_channel
  import biquad_pkg::*;
#(
  parameter int NUM_SEC = 7,
  parameter int SEC_W   = $clog2(NUM_SEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEC_W-1:0] cfg_sec,
  input  logic [FLD_W-1:0] cfg_field,
  input  logic [CW-1:0]    cfg_wdata,
  input  logic             start,
  input  logic             step,
  input  logic             last,
  input  logic [SEC_W-1:0] sec,
  input  logic [SW-1:0]    x_in,
  output logic [SW-1:0]    y_sample
);
  sec_cfg_t act;
  logic signed [SW-1:0] x_cur_q;
  logic signed [SW-1:0] y_filt;
  logic signed [SW-1:0] y_out;
  logic [SW-1:0] y_q;

  logic [NUM_SEC-1:0][SW-1:0] x1_q, x2_q, y1_q, y2_q;
  logic [4*NUM_SEC*SW-1:0]    hist_all;

  logic bypass_step;
  logic rect_step;

  bq_coef_bank #(.NUM_SEC(NUM_SEC), .SEC_W(SEC_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we(cfg_we), .wr_sec(cfg_sec), .wr_field(cfg_field), .wr_data(cfg_wdata),
    .commit(start), .rd_sec(sec), .rd_cfg(act)
  );

  bq_section_math u_math (
    .cfg(act), .x0(x_cur_q),
    .x1($signed(x1_q[sec])), .x2($signed(x2_q[sec])),
    .y1($signed(y1_q[sec])), .y2($signed(y2_q[sec])),
    .y_filt(y_filt), .y_out(y_out)
  );

  assign bypass_step = step && act.mode.bypass;
  assign rect_step   = step && act.mode.rect && !act.mode.bypass;
  assign hist_all    = {x1_q, x2_q, y1_q, y2_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_cur_q <= '0;
      y_q     <= '0;
      x1_q    <= '0;
      x2_q    <= '0;
      y1_q    <= '0;
      y2_q    <= '0;
    end else if (start) begin
      x_cur_q <= x_in;
    end else if (step) begin
      x_cur_q <= y_out;
      if (!act.mode.bypass) begin
        x1_q[sec] <= x_cur_q;
        x2_q[sec] <= x1_q[sec];
        y1_q[sec] <= y_filt;
        y2_q[sec] <= y1_q[sec];
      end
      if (last) y_q <= y_out;
    end
  end

  assign y_sample = y_q;

  // R6: a bypassed section leaves every history register as it was
  p_bypass_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_step |=> $stable(hist_all));

  // R5: a rectified section never passes on a negative value
  p_rect_nonneg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rect_step |-> !y_out[SW-1]);
endmodule

// File: rtl/biquad_cascade.sv
module biquad_cascade
  import biquad_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_SEC = 7,
  localparam int SEC_W  = $clog2(NUM_SEC),
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CH_W-1:0]      cfg_ch,
  input  logic [SEC_W-1:0]     cfg_sec,
  input  logic [FLD_W-1:0]     cfg_field,
  input  logic [CW-1:0]        cfg_wdata,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NUM_CH*SW-1:0] in_data,
  output logic                 out_valid,
  output logic [NUM_CH*SW-1:0] out_data
);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(NUM_SEC - 1);

  logic             busy_q;
  logic [SEC_W-1:0] sec_q;
  logic             out_valid_q;
  logic             accept;
  logic             last;

  assign accept   = in_valid && !busy_q;
  assign last     = busy_q && (sec_q == SEC_LAST);
  assign in_ready = !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      sec_q       <= '0;
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= last;
      if (accept) begin
        busy_q <= 1'b1;
        sec_q  <= '0;
      end else if (busy_q) begin
        if (last) busy_q <= 1'b0;
        else      sec_q  <= sec_q + SEC_W'(1);
      end
    end
  end

  assign out_valid = out_valid_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ch_we;
    assign ch_we = cfg_we && (cfg_ch == CH_W'(c));

    bq_channel #(.NUM_SEC(NUM_SEC), .SEC_W(SEC_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(ch_we), .cfg_sec(cfg_sec), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
      .start(accept), .step(busy_q), .last(last), .sec(sec_q),
      .x_in(in_data[c*SW +: SW]), .y_sample(out_data[c*SW +: SW])
    );
  end

  // R1: acceptance starts the walk at the first section
  p_accept_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_q && sec_q == '0));

  // R1: the final section produces the result and frees the input
  p_last_emits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (out_valid && in_ready));

  // R1: the result strobe lasts one cycle
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

// File: tb/biquad_cascade_test.sv
`timescale 1ns/1ps
module biquad_cascade_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [2:0]  cfg_sec = '0;
  logic [2:0]  cfg_field = '0;
  logic [15:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic [63:0] out_data;

  biquad_cascade uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sec(cfg_sec),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench model: shadow/active fields (0..5) and section histories
  int sh [4][7][6];
  int ac [4][7][6];
  int hx1[4][7], hx2[4][7], hy1[4][7], hy2[4][7];

  logic [63:0] exp_q[$];
  int          cyc_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 7; s++) begin
        for (int f = 0; f < 6; f++) begin
          sh[c][s][f] = (f == 5) ? 8 : 0;
          ac[c][s][f] = (f == 5) ? 8 : 0;
        end
        hx1[c][s] = 0; hx2[c][s] = 0; hy1[c][s] = 0; hy2[c][s] = 0;
      end
  endtask

  function automatic int clamp16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic logic [63:0] model_run(input logic [63:0] smp);
    logic [63:0] r;
    r = '0;
    for (int c = 0; c < 4; c++) begin
      int x;
      x = int'($signed(smp[c*16 +: 16]));
      for (int s = 0; s < 7; s++) begin
        longint b0, b1, b2, a1, a2, nm, acc;
        int m, yf;
        m = ac[c][s][5];
        if (((m >> 3) & 1) == 0) begin
          b0 = ac[c][s][0]; b1 = ac[c][s][1]; b2 = ac[c][s][2];
          a1 = ac[c][s][3]; a2 = ac[c][s][4];
          case (m & 3)
            1: nm = b0 * (longint'(x) + 2 * longint'(hx1[c][s]) + longint'(hx2[c][s]));
            2: nm = b0 * (longint'(x) - 2 * longint'(hx1[c][s]) + longint'(hx2[c][s]));
            3: nm = b0 * (longint'(x) - longint'(hx2[c][s]));
            default: nm = b0 * x + b1 * hx1[c][s] + b2 * hx2[c][s];
          endcase
          acc = nm - a1 * hy1[c][s] - a2 * hy2[c][s];
          yf = clamp16(acc >>> 14);
          hx2[c][s] = hx1[c][s]; hx1[c][s] = x;
          hy2[c][s] = hy1[c][s]; hy1[c][s] = yf;
          if (((m >> 2) & 1) == 1) x = (yf < 0) ? clamp16(-longint'(yf)) : yf;
          else x = yf;
        end
      end
      r[c*16 +: 16] = x[15:0];
    end
    return r;
  endfunction

  function automatic logic [63:0] pat(input int i, input int k);
    logic [63:0] r;
    for (int c = 0; c < 4; c++) r[c*16 +: 16] = 16'((i * 9973 + c * 4099 + k * 31337) & 16'hFFFF);
    return r;
  endfunction

  task automatic model_write(input int c, input int s, input int f, input logic [15:0] d);
    if (s < 7 && f < 6) sh[c][s][f] = (f == 5) ? int'(d[3:0]) : int'($signed(d));
  endtask

  // driver: accept a vector, optionally with a write on the same edge
  task automatic send_w(input logic [63:0] smp, input string tag, input bit wr,
                        input int c, input int s, input int f, input logic [15:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data = smp;
    if (wr) begin
      cfg_we = 1'b1; cfg_ch = 2'(c); cfg_sec = 3'(s); cfg_field = 3'(f); cfg_wdata = d;
    end
    @(posedge clk);
    #1;
    for (int cc = 0; cc < 4; cc++)
      for (int ss = 0; ss < 7; ss++)
        for (int ff = 0; ff < 6; ff++) ac[cc][ss][ff] = sh[cc][ss][ff];
    exp_q.push_back(model_run(smp));
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
    if (wr) model_write(c, s, f, d);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b0;
    chk(in_ready == 1'b0, "R1", "in_ready while busy", in_ready, 0);
  endtask

  task automatic send(input logic [63:0] smp, input string tag);
    send_w(smp, tag, 1'b0, 0, 0, 0, 16'h0);
  endtask

  task automatic wr(input int c, input int s, input int f, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(c); cfg_sec = 3'(s); cfg_field = 3'(f); cfg_wdata = d;
    @(posedge clk);
    #1;
    model_write(c, s, f, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 100) begin
      @(negedge clk);
      t++;
    end
    chk(exp_q.size() == 0, "R1", "pending results", exp_q.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    chk(out_data == 64'h0, "R9", "out_data after reset", out_data, 0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
    rst_n = 1'b1;
  endtask

  // monitor: pop expected results as the design emits them
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected out_valid", 1, 0);
      end else begin
        logic [63:0] e;
        int ec;
        string tg;
        e = exp_q.pop_front();
        ec = cyc_q.pop_front();
        tg = tag_q.pop_front();
        chk(out_data == e, tg, "out_data", out_data, e);
        chk(cyc == ec + 7, "R1", "result latency", cyc - ec, 7);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();

    // R6 / R1: all sections bypassed -> identity
    for (int i = 0; i < 4; i++) send(pat(i, 1), "R6");
    send(64'h8000_7FFF_0000_FFFF, "R6");
    drain();

    // R2 / R10: general section with feedback on channel 0 only
    wr(0, 0, 0, 16'd8192);
    wr(0, 0, 1, 16'd4096);
    wr(0, 0, 2, -16'sd2048);
    wr(0, 0, 3, -16'sd8192);
    wr(0, 0, 4, 16'd1024);
    wr(0, 0, 5, 16'h0000);
    for (int i = 0; i < 6; i++) send(pat(i, 2), "R2");
    drain();

    // R3: lowpass, highpass, bandpass on different channels and positions
    wr(1, 2, 0, 16'd2000); wr(1, 2, 3, -16'sd12000); wr(1, 2, 4, 16'd5000); wr(1, 2, 5, 16'h0001);
    wr(2, 4, 0, 16'd9000); wr(2, 4, 3, 16'd3000);    wr(2, 4, 5, 16'h0002);
    wr(3, 6, 0, 16'd7000); wr(3, 6, 4, 16'd2000);    wr(3, 6, 5, 16'h0003);
    for (int i = 0; i < 8; i++) send(pat(i, 3), "R3");
    drain();

    // R4: gain near 2 pushes large inputs into saturation
    wr(0, 1, 0, 16'd32767);
    wr(0, 1, 5, 16'h0000);
    send(64'h0000_0000_0000_7530, "R4");
    send(64'h0000_0000_0000_8AD0, "R4");
    send(64'h1234_8000_7FFF_7FFF, "R4");
    drain();

    // R5: rectify on channel 3 (lowpass at 6 replaced by unity general with rectify)
    wr(3, 6, 0, 16'd16384); wr(3, 6, 4, 16'd0); wr(3, 6, 5, 16'h0004);
    send(64'hFB2E_0000_0000_0000, "R5");
    send(64'h8000_0000_0000_0000, "R5");
    send(64'h04D2_0000_0000_0000, "R5");
    drain();

    // R7: field codes 6/7 and section 7 change nothing
    wr(0, 0, 6, 16'h7FFF);
    wr(0, 0, 7, 16'h1111);
    wr(0, 7, 0, 16'h2222);
    wr(1, 7, 5, 16'h0008);
    for (int i = 0; i < 3; i++) send(pat(i, 7), "R7");
    drain();

    // R8: write on the accept edge applies to the next sample only
    send_w(pat(1, 8), "R8", 1'b1, 0, 0, 0, 16'd16384);
    send(pat(2, 8), "R8");
    // R8: write while a sample is in flight
    send(pat(3, 8), "R8");
    wr(2, 4, 0, -16'sd9000);
    send(pat(4, 8), "R8");
    drain();

    // R9: reset clears history and coefficients
    do_reset();
    send(pat(5, 9), "R9");
    wr(0, 0, 0, 16'd4096); wr(0, 0, 1, 16'd8192); wr(0, 0, 5, 16'h0000);
    send(pat(6, 9), "R9");
    send(pat(7, 9), "R9");
    drain();
    do_reset();
    wr(0, 0, 0, 16'd4096); wr(0, 0, 1, 16'd8192); wr(0, 0, 5, 16'h0000);
    send(pat(6, 9), "R9");
    drain();

    // R10: back-to-back vectors with distinct channel programs
    wr(1, 0, 0, 16'd12000); wr(1, 0, 5, 16'h0001);
    for (int i = 0; i < 4; i++) send(pat(i, 10), "R10");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule